// File: doc/BRIEF.md
# Area-weighted pileup subtractor

This block removes an estimated pileup contribution from calorimeter tower energies on a streaming path. Each cycle it may accept one tower record made of a tower identifier, an eta index, a flag marking the deeper forward sections, signed EM and HAD energies in MeV, and one area weight for each layer. Five regional pileup densities, in counts, are held on static inputs for the length of a frame. The block computes no densities and applies no noise cuts.

For each layer, the block picks one density from the tower's eta region and layer. It multiplies that density by the layer's area weight and shifts the product down by a fixed number of bits, so the fractional part is dropped. It then scales the result to MeV with the region's unit and subtracts it from the energy. The corrected energies come out two cycles after the record, next to the raw energies, with a valid flag and the tower identifier delayed to match. Any number of records may be sent back to back.

Top module: `pileup_sub`

## Requirements
- R1: An accepted record (inValid high at a rising edge) appears on the outputs exactly two rising edges later with outValid high and outTowerId equal to its identifier. outValid is low two edges after any edge where inValid was low.
- R2: For eta below 32, the EM energy is reduced by ((rhoEm × emArea) >> AREA_SHIFT) × 25.
- R3: For eta 0 to 14, the HAD energy is reduced by ((rhoHad1 × hadArea) >> AREA_SHIFT) × 500.
- R4: For eta exactly 15, the HAD energy is reduced by ((rhoHad2 × hadArea) >> AREA_SHIFT) × 25.
- R5: For eta 16 to 31, the HAD energy is reduced by ((rhoHad3 × hadArea) >> AREA_SHIFT) × 25.
- R6: For eta 32 or above with inDeepFwd = 1, the HAD energy is reduced by ((rhoFwd × hadArea) >> AREA_SHIFT) × 25 and the EM energy is left uncorrected.
- R7: For eta 32 or above with inDeepFwd = 0, the EM energy is reduced by ((rhoFwd × emArea) >> AREA_SHIFT) × 25 and the HAD energy is left uncorrected.
- R8: A record with tower identifier 0 leaves both energies uncorrected.
- R9: Corrected energies are two's-complement values on OUT_W bits. They may go negative and are not clamped. The shift drops the fraction before the unit is applied.
- R10: outEmRaw and outHadRaw carry the record's input energies unchanged.
- R11: While rstN is low, and after it is released until a record has passed through, outValid is low.
- R12: Records sent on consecutive cycles come out on consecutive cycles, in order, each corrected with its own region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Record present this cycle |
| inTowerId | input | ID_W | Tower identifier; 0 means no correction |
| inEta | input | ETA_W | Absolute eta index |
| inDeepFwd | input | 1 | 1 = deeper forward section (HAD corrected), 0 = first forward section (EM corrected) |
| inEmEt | input | ET_W | Signed EM energy, MeV |
| inHadEt | input | ET_W | Signed HAD energy, MeV |
| inEmArea | input | AREA_W | EM area weight |
| inHadArea | input | AREA_W | HAD area weight |
| rhoEm | input | RHO_W | EM density, central |
| rhoHad1 | input | RHO_W | HAD density, eta 0 to 14 |
| rhoHad2 | input | RHO_W | HAD density, eta 15 |
| rhoHad3 | input | RHO_W | HAD density, eta 16 to 31 |
| rhoFwd | input | RHO_W | Forward density |
| outValid | output | 1 | Output record valid |
| outTowerId | output | ID_W | Delayed tower identifier |
| outEmRaw | output | ET_W | Delayed raw EM energy |
| outHadRaw | output | ET_W | Delayed raw HAD energy |
| outEmCorr | output | OUT_W | Corrected EM energy |
| outHadCorr | output | OUT_W | Corrected HAD energy |

## Verification
When records are sent back to back, one record is having its product selected and shifted in the first stage while the record before it is having its unit applied and being subtracted in the second stage. A mix-up of region selects or units between the two stages would then corrupt both. The bench streams a run of records with alternating regions, layers and zero identifiers on consecutive cycles. It compares each output cycle against a model worked out from the region rules. Single-record tests set the result of each region apart from the others first.

// File: rtl/pileup_sub_pkg.sv
package pileup_sub_pkg;

  // eta boundaries where the density selection changes
  localparam int GAP_ETA = 15;
  localparam int MID_ETA = 16;
  localparam int FWD_ETA = 32;

  typedef enum logic [1:0] {
    HAD_TILE = 2'd0,
    HAD_GAP  = 2'd1,
    HAD_MID  = 2'd2,
    HAD_FWD  = 2'd3
  } hadRegion_e;

  // strobes and selects from control to datapath
  typedef struct packed {
    logic       cap1;      // capture stage-1 registers
    logic       cap2;      // capture output registers
    logic       emApply;   // EM layer gets a correction
    logic       emUseFwd;  // EM uses the forward density
    logic       hadApply;  // HAD layer gets a correction
    hadRegion_e hadSel;    // HAD density select
  } pipeCtl_t;

endpackage

// File: rtl/pileup_sub_ctrl.sv
module pileup_sub_ctrl
  import pileup_sub_pkg::*;
#(
  parameter int ID_W  = 12,
  parameter int ETA_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [ID_W-1:0]  inTowerId,
  input  logic [ETA_W-1:0] inEta,
  input  logic             inDeepFwd,
  output pipeCtl_t         ctl,
  output logic             outValid
);

  logic s1Valid;
  logic idLive;
  logic isFwd;

  always_comb begin
    idLive = (inTowerId != '0);
    isFwd  = (32'(inEta) >= 32'(FWD_ETA));

    ctl.cap1     = inValid;
    ctl.cap2     = s1Valid;
    ctl.emApply  = idLive && (!isFwd || !inDeepFwd);
    ctl.emUseFwd = isFwd;
    ctl.hadApply = idLive && (!isFwd || inDeepFwd);

    if (isFwd)                                  ctl.hadSel = HAD_FWD;
    else if (32'(inEta) >= 32'(MID_ETA))        ctl.hadSel = HAD_MID;
    else if (32'(inEta) == 32'(GAP_ETA))        ctl.hadSel = HAD_GAP;
    else                                        ctl.hadSel = HAD_TILE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

endmodule

// File: rtl/pileup_sub_dp.sv
module pileup_sub_dp
  import pileup_sub_pkg::*;
#(
  parameter int ID_W        = 12,
  parameter int ET_W        = 20,
  parameter int RHO_W       = 12,
  parameter int AREA_W      = 10,
  parameter int AREA_SHIFT  = 7,
  parameter int UNIT_FINE   = 25,
  parameter int UNIT_COARSE = 500,
  parameter int OUT_W       = 25
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pipeCtl_t                ctl,
  input  logic [ID_W-1:0]         inTowerId,
  input  logic signed [ET_W-1:0]  inEmEt,
  input  logic signed [ET_W-1:0]  inHadEt,
  input  logic [AREA_W-1:0]       inEmArea,
  input  logic [AREA_W-1:0]       inHadArea,
  input  logic [RHO_W-1:0]        rhoEm,
  input  logic [RHO_W-1:0]        rhoHad1,
  input  logic [RHO_W-1:0]        rhoHad2,
  input  logic [RHO_W-1:0]        rhoHad3,
  input  logic [RHO_W-1:0]        rhoFwd,
  output logic [ID_W-1:0]         outTowerId,
  output logic signed [ET_W-1:0]  outEmRaw,
  output logic signed [ET_W-1:0]  outHadRaw,
  output logic signed [OUT_W-1:0] outEmCorr,
  output logic signed [OUT_W-1:0] outHadCorr
);

  localparam int PROD_W = RHO_W + AREA_W;
  localparam int CNT_W  = PROD_W - AREA_SHIFT;
  localparam logic [OUT_W-1:0] FINE_K   = OUT_W'(UNIT_FINE);
  localparam logic [OUT_W-1:0] COARSE_K = OUT_W'(UNIT_COARSE);

  // stage 1: density select, area product, shift
  logic [RHO_W-1:0]  emRho, hadRho;
  logic [PROD_W-1:0] emProd, hadProd;
  logic [CNT_W-1:0]  emCnt, hadCnt;

  always_comb begin
    emRho = ctl.emUseFwd ? rhoFwd : rhoEm;
    unique case (ctl.hadSel)
      HAD_TILE: hadRho = rhoHad1;
      HAD_GAP:  hadRho = rhoHad2;
      HAD_MID:  hadRho = rhoHad3;
      default:  hadRho = rhoFwd;
    endcase
    emProd  = PROD_W'(emRho)  * PROD_W'(inEmArea);
    hadProd = PROD_W'(hadRho) * PROD_W'(inHadArea);
    emCnt   = ctl.emApply  ? emProd[PROD_W-1:AREA_SHIFT]  : '0;
    hadCnt  = ctl.hadApply ? hadProd[PROD_W-1:AREA_SHIFT] : '0;
  end

  logic [CNT_W-1:0]       s1EmCnt, s1HadCnt;
  logic                   s1HadCoarse;
  logic [ID_W-1:0]        s1Id;
  logic signed [ET_W-1:0] s1EmRaw, s1HadRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1EmCnt     <= '0;
      s1HadCnt    <= '0;
      s1HadCoarse <= 1'b0;
      s1Id        <= '0;
      s1EmRaw     <= '0;
      s1HadRaw    <= '0;
    end else if (ctl.cap1) begin
      s1EmCnt     <= emCnt;
      s1HadCnt    <= hadCnt;
      s1HadCoarse <= (ctl.hadSel == HAD_TILE);
      s1Id        <= inTowerId;
      s1EmRaw     <= inEmEt;
      s1HadRaw    <= inHadEt;
    end
  end

  // stage 2: unit scaling and subtraction
  logic [OUT_W-1:0]        emAmt, hadAmt;
  logic signed [OUT_W-1:0] emNext, hadNext;

  always_comb begin
    emAmt   = OUT_W'(s1EmCnt) * FINE_K;
    hadAmt  = OUT_W'(s1HadCnt) * (s1HadCoarse ? COARSE_K : FINE_K);
    emNext  = OUT_W'(s1EmRaw)  - $signed(emAmt);
    hadNext = OUT_W'(s1HadRaw) - $signed(hadAmt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outTowerId <= '0;
      outEmRaw   <= '0;
      outHadRaw  <= '0;
      outEmCorr  <= '0;
      outHadCorr <= '0;
    end else if (ctl.cap2) begin
      outTowerId <= s1Id;
      outEmRaw   <= s1EmRaw;
      outHadRaw  <= s1HadRaw;
      outEmCorr  <= emNext;
      outHadCorr <= hadNext;
    end
  end

endmodule

// File: rtl/pileup_sub.sv
module pileup_sub
  import pileup_sub_pkg::*;
#(
  parameter int ID_W        = 12,
  parameter int ETA_W       = 6,
  parameter int ET_W        = 20,
  parameter int RHO_W       = 12,
  parameter int AREA_W      = 10,
  parameter int AREA_SHIFT  = 7,
  parameter int UNIT_FINE   = 25,
  parameter int UNIT_COARSE = 500,
  parameter int UNIT_W      = $clog2(UNIT_COARSE + 1),
  parameter int CORR_W      = RHO_W + AREA_W - AREA_SHIFT + UNIT_W,
  parameter int OUT_W       = ((CORR_W > ET_W) ? CORR_W : ET_W) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [ID_W-1:0]         inTowerId,
  input  logic [ETA_W-1:0]        inEta,
  input  logic                    inDeepFwd,
  input  logic signed [ET_W-1:0]  inEmEt,
  input  logic signed [ET_W-1:0]  inHadEt,
  input  logic [AREA_W-1:0]       inEmArea,
  input  logic [AREA_W-1:0]       inHadArea,
  input  logic [RHO_W-1:0]        rhoEm,
  input  logic [RHO_W-1:0]        rhoHad1,
  input  logic [RHO_W-1:0]        rhoHad2,
  input  logic [RHO_W-1:0]        rhoHad3,
  input  logic [RHO_W-1:0]        rhoFwd,
  output logic                    outValid,
  output logic [ID_W-1:0]         outTowerId,
  output logic signed [ET_W-1:0]  outEmRaw,
  output logic signed [ET_W-1:0]  outHadRaw,
  output logic signed [OUT_W-1:0] outEmCorr,
  output logic signed [OUT_W-1:0] outHadCorr
);

  pipeCtl_t ctl;

  pileup_sub_ctrl #(.ID_W(ID_W), .ETA_W(ETA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTowerId(inTowerId),
    .inEta(inEta), .inDeepFwd(inDeepFwd), .ctl(ctl), .outValid(outValid)
  );

  pileup_sub_dp #(
    .ID_W(ID_W), .ET_W(ET_W), .RHO_W(RHO_W), .AREA_W(AREA_W),
    .AREA_SHIFT(AREA_SHIFT), .UNIT_FINE(UNIT_FINE),
    .UNIT_COARSE(UNIT_COARSE), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inTowerId(inTowerId),
    .inEmEt(inEmEt), .inHadEt(inHadEt), .inEmArea(inEmArea),
    .inHadArea(inHadArea), .rhoEm(rhoEm), .rhoHad1(rhoHad1),
    .rhoHad2(rhoHad2), .rhoHad3(rhoHad3), .rhoFwd(rhoFwd),
    .outTowerId(outTowerId), .outEmRaw(outEmRaw), .outHadRaw(outHadRaw),
    .outEmCorr(outEmCorr), .outHadCorr(outHadCorr)
  );

endmodule

// File: rtl/pileup_sub_chk.sv
module pileup_sub_chk #(
  parameter int ID_W  = 12,
  parameter int ETA_W = 6,
  parameter int ET_W  = 20,
  parameter int OUT_W = 25
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [ID_W-1:0]         inTowerId,
  input logic [ETA_W-1:0]        inEta,
  input logic                    inDeepFwd,
  input logic signed [ET_W-1:0]  inEmEt,
  input logic signed [ET_W-1:0]  inHadEt,
  input logic                    outValid,
  input logic [ID_W-1:0]         outTowerId,
  input logic signed [ET_W-1:0]  outEmRaw,
  input logic signed [ET_W-1:0]  outHadRaw,
  input logic signed [OUT_W-1:0] outEmCorr,
  input logic signed [OUT_W-1:0] outHadCorr
);

  // edges seen since reset release, saturating at two
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            seen <= 2'd0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd2) |-> (outValid == $past(inValid, 2)));

  p_id_delay_r1: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd2 && outValid) |-> (outTowerId == $past(inTowerId, 2)));

  p_raw_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd2 && outValid) |->
      (outEmRaw == $past(inEmEt, 2) && outHadRaw == $past(inHadEt, 2)));

  p_zero_id_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTowerId == '0) |->
      (outEmCorr == OUT_W'(outEmRaw) && outHadCorr == OUT_W'(outHadRaw)));

  p_first_fwd_had_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd2 && outValid && 32'($past(inEta, 2)) >= 32'd32 && !$past(inDeepFwd, 2))
      |-> (outHadCorr == OUT_W'(outHadRaw)));

  p_deep_fwd_em_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seen == 2'd2 && outValid && 32'($past(inEta, 2)) >= 32'd32 && $past(inDeepFwd, 2))
      |-> (outEmCorr == OUT_W'(outEmRaw)));

endmodule

bind pileup_sub pileup_sub_chk #(
  .ID_W(ID_W), .ETA_W(ETA_W), .ET_W(ET_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTowerId(inTowerId),
  .inEta(inEta), .inDeepFwd(inDeepFwd), .inEmEt(inEmEt), .inHadEt(inHadEt),
  .outValid(outValid), .outTowerId(outTowerId), .outEmRaw(outEmRaw),
  .outHadRaw(outHadRaw), .outEmCorr(outEmCorr), .outHadCorr(outHadCorr)
);

// File: tb/pileup_sub_tb.sv
`timescale 1ns/1ps
module pileup_sub_tb;

  localparam int ID_W = 12, ETA_W = 6, ET_W = 20, RHO_W = 12, AREA_W = 10;
  localparam int SH = 7;
  localparam int OUT_W = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [ID_W-1:0] inTowerId = '0;
  logic [ETA_W-1:0] inEta = '0;
  logic inDeepFwd = 1'b0;
  logic signed [ET_W-1:0] inEmEt = '0, inHadEt = '0;
  logic [AREA_W-1:0] inEmArea = '0, inHadArea = '0;
  logic [RHO_W-1:0] rhoEm = '0, rhoHad1 = '0, rhoHad2 = '0, rhoHad3 = '0, rhoFwd = '0;
  logic outValid;
  logic [ID_W-1:0] outTowerId;
  logic signed [ET_W-1:0] outEmRaw, outHadRaw;
  logic signed [OUT_W-1:0] outEmCorr, outHadCorr;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  pileup_sub u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTowerId(inTowerId),
    .inEta(inEta), .inDeepFwd(inDeepFwd), .inEmEt(inEmEt), .inHadEt(inHadEt),
    .inEmArea(inEmArea), .inHadArea(inHadArea), .rhoEm(rhoEm),
    .rhoHad1(rhoHad1), .rhoHad2(rhoHad2), .rhoHad3(rhoHad3), .rhoFwd(rhoFwd),
    .outValid(outValid), .outTowerId(outTowerId), .outEmRaw(outEmRaw),
    .outHadRaw(outHadRaw), .outEmCorr(outEmCorr), .outHadCorr(outHadCorr)
  );

  task automatic check(input string req, input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // expected corrected energies from the region rules
  function automatic longint corrEm(input int id, input int eta, input bit deep,
                                    input int em, input int aEm);
    if (id == 0) return em;
    if (eta < 32) return em - ((int'(rhoEm) * aEm) >>> SH) * 25;
    if (!deep)    return em - ((int'(rhoFwd) * aEm) >>> SH) * 25;
    return em;
  endfunction

  function automatic longint corrHad(input int id, input int eta, input bit deep,
                                     input int had, input int aHad);
    if (id == 0) return had;
    if (eta < 15)  return had - ((int'(rhoHad1) * aHad) >>> SH) * 500;
    if (eta == 15) return had - ((int'(rhoHad2) * aHad) >>> SH) * 25;
    if (eta < 32)  return had - ((int'(rhoHad3) * aHad) >>> SH) * 25;
    if (deep)      return had - ((int'(rhoFwd) * aHad) >>> SH) * 25;
    return had;
  endfunction

  task automatic drive(input int id, input int eta, input bit deep,
                       input int em, input int had, input int aEm, input int aHad);
    inValid   = 1'b1;
    inTowerId = ID_W'(id);
    inEta     = ETA_W'(eta);
    inDeepFwd = deep;
    inEmEt    = ET_W'(em);
    inHadEt   = ET_W'(had);
    inEmArea  = AREA_W'(aEm);
    inHadArea = AREA_W'(aHad);
  endtask

  // one record; outputs sampled at the second falling edge after driving
  task automatic oneRecord(input string req, input int id, input int eta, input bit deep,
                           input int em, input int had, input int aEm, input int aHad);
    @(negedge clk);
    drive(id, eta, deep, em, had, aEm, aHad);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R1 latency valid"}, outValid, 0);
    @(negedge clk);
    check({req, " R1 valid"}, outValid, 1);
    check({req, " R1 id"}, outTowerId, id);
    check({req, " R10 em raw"}, outEmRaw, em);
    check({req, " R10 had raw"}, outHadRaw, had);
    check({req, " em corr"}, outEmCorr, corrEm(id, eta, deep, em, aEm));
    check({req, " had corr"}, outHadCorr, corrHad(id, eta, deep, had, aHad));
    @(negedge clk);
    check({req, " R1 valid drop"}, outValid, 0);
  endtask

  task automatic t_reset();
    check("R11 reset valid", outValid, 0);
    repeat (3) @(negedge clk);
    check("R11 idle valid", outValid, 0);
  endtask

  task automatic t_central();
    rhoEm = 12'd300; rhoHad1 = 12'd3; rhoHad2 = 12'd40; rhoHad3 = 12'd70; rhoFwd = 12'd90;
    oneRecord("R2 R3 tile", 7, 4, 1'b0, 10000, 6000, 128, 128);   // em 10000-7500, had 6000-1500
    oneRecord("R4 gap", 9, 15, 1'b0, 5000, 5000, 128, 256);       // had 5000-80*25
    oneRecord("R5 mid", 11, 20, 1'b0, 5000, 5000, 64, 128);
    oneRecord("R5 edge31", 12, 31, 1'b1, 4000, 4000, 128, 128);
  endtask

  task automatic t_forward();
    oneRecord("R6 deep", 21, 35, 1'b1, 3000, 9000, 128, 200);
    oneRecord("R7 first", 22, 32, 1'b0, 9000, 3000, 200, 128);
    check("R7 had untouched", outHadCorr, 3000);
  endtask

  task automatic t_zero_id();
    oneRecord("R8 zero id", 0, 4, 1'b0, 1234, 5678, 500, 500);
    check("R8 em untouched", outEmCorr, 1234);
  endtask

  task automatic t_negative();
    // 300*100=30000, >>7 = 234, *25 = 5850; 1000-5850 = -4850
    oneRecord("R9 negative", 5, 2, 1'b0, 1000, -200, 100, 300);
    check("R9 negative em", outEmCorr, -4850);
  endtask

  task automatic t_stream();
    int ids[8]   = '{3, 0, 17, 18, 19, 20, 21, 22};
    int etas[8]  = '{1, 5, 15, 33, 33, 24, 40, 14};
    bit deeps[8] = '{0, 0, 0, 1, 0, 0, 1, 1};
    int ems[8]   = '{800, 900, 2000, -300, 7000, 1500, 2500, 100};
    int hads[8]  = '{4000, 100, 3000, 6000, 800, 2200, 5000, 9000};
    int aEms[8]  = '{128, 300, 90, 64, 255, 128, 30, 1000};
    int aHads[8] = '{256, 10, 200, 512, 128, 77, 600, 129};
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int k = c - 2;
        check("R12 stream valid", outValid, 1);
        check("R12 stream id", outTowerId, ids[k]);
        check("R12 stream em", outEmCorr, corrEm(ids[k], etas[k], deeps[k], ems[k], aEms[k]));
        check("R12 stream had", outHadCorr, corrHad(ids[k], etas[k], deeps[k], hads[k], aHads[k]));
      end
      if (c < 8) drive(ids[c], etas[c], deeps[c], ems[c], hads[c], aEms[c], aHads[c]);
      else inValid = 1'b0;
    end
    @(negedge clk);
    check("R12 stream end", outValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_central();
    t_forward();
    t_zero_id();
    t_negative();
    t_stream();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule